// File: doc/BRIEF.md
# Deflection Safety and Blanking Controller

This block gathers the protection and status conditions of a monitor deflection controller and turns them into three control outputs: an inhibit for the horizontal drive stage, an inhibit for the vertical drive stage and a composite blanking signal for the video path. The analog threshold detectors sit outside the block. Each of their results arrives as a digital flag, as do the timing pulses (horizontal flyback, vertical flyback, vertical sync, vertical ramp retrace) and the unlock report from the horizontal phase-locked loop.

Every flag passes through its own synchroniser before it is used. Two small state machines hold the only memory in the block. The fault latch (states `XR_UNPOWERED`, `XR_NORMAL`, `XR_TRIPPED`) records an X-ray trip. Only a loss of supply can clear it. Its transitions are: supply lost from any state goes to `XR_UNPOWERED`; `XR_UNPOWERED` with supply good goes to `XR_NORMAL`; `XR_NORMAL` with a fault goes to `XR_TRIPPED`. The frequency-change blanker (states `FB_IDLE`, `FB_HOLD`) stretches each rising edge of the unlock flag into a blanking window whose length in clock cycles comes from an input. Its transitions are: a rising unlock edge with a non-zero length moves `FB_IDLE` to `FB_HOLD` and loads the counter; a new edge in `FB_HOLD` reloads the counter; the last counted cycle moves `FB_HOLD` back to `FB_IDLE`. All other conditions act on the outputs directly and are not remembered.

Top module: `defl_guard`

## Requirements
- R1: During reset, and after reset until a high `supply_ok` has been synchronised, `h_inhibit`, `v_inhibit` and `cblank` are all 1.
- R2: A change on any level input (`supply_ok`, `standby`, `hfly`, `vfly`, `vsync`, `vretrace`, `vfly_dis`) reaches the outputs exactly two clock edges after it is applied, and not after one.
- R3: `h_inhibit` is 1 when supply is low, when the X-ray latch is set, during horizontal flyback, or during standby. Horizontal flyback alone does not set `v_inhibit`.
- R4: `v_inhibit` is 1 only when supply is low or standby is requested. It is 0 when the X-ray latch alone is set.
- R5: A high `xray_trip` sets the latch. `h_inhibit` and `cblank` are raised three clock edges after the fault is applied, and they stay raised after `xray_trip` returns to 0.
- R6: The X-ray latch is cleared only while supply is low. After supply returns with no fault present, `h_inhibit` and `cblank` are 0.
- R7: Standby raises all three outputs and is not remembered: two edges after `standby` is removed, all three outputs are 0 again.
- R8: `cblank` is 1 on any of the following: low supply, standby, set X-ray latch, horizontal flyback, vertical sync, the vertical blanking source (see R9), or an active frequency-change window.
- R9: With `vfly_dis` = 0 the vertical blanking source is `vfly` and `vretrace` is ignored. With `vfly_dis` = 1 the source is `vretrace` and `vfly` is ignored.
- R10: A rising edge on `unlock` opens a blanking window that shows on `cblank` from the third clock edge after the edge and lasts exactly `blank_len` cycles.
- R11: A new rising edge on `unlock` during an open window restarts the count, so the window ends `blank_len` cycles after the new edge takes effect.
- R12: With `blank_len` = 0, a rising edge on `unlock` opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the working threshold |
| xray_trip | input | 1 | X-ray comparator has tripped |
| standby | input | 1 | Duty control below the off threshold |
| hfly | input | 1 | Horizontal flyback pulse |
| vfly | input | 1 | Vertical flyback pulse |
| vsync | input | 1 | Vertical sync pulse |
| vretrace | input | 1 | Vertical ramp discharge interval |
| unlock | input | 1 | Horizontal loop reports unlock |
| vfly_dis | input | 1 | Use the retrace interval in place of vertical flyback |
| blank_len | input | BLANK_W | Frequency-change window length in cycles |
| h_inhibit | output | 1 | Stop the horizontal drive |
| v_inhibit | output | 1 | Stop the vertical drive |
| cblank | output | 1 | Composite blanking |

## Verification
Level-driven results are due two clock edges after the stimulus, because of the synchroniser. Effects of the X-ray latch and the start of a frequency-change window are due on the third edge, because their state register adds one stage. A window closes `blank_len` edges after it opens. The bench drives inputs just after a falling edge and then counts falling edges, so every sample falls between rising edges. For each latency it samples once on the last cycle before the result is due, where the old value must still hold, and once on the cycle where the new value is due, so a design that is one cycle early or one cycle late fails a check.

// File: rtl/defl_pkg.sv
package defl_pkg;

    typedef enum logic [1:0] {
        XR_UNPOWERED = 2'd0,
        XR_NORMAL    = 2'd1,
        XR_TRIPPED   = 2'd2
    } xr_state_t;

    typedef enum logic {
        FB_IDLE = 1'b0,
        FB_HOLD = 1'b1
    } fb_state_t;

    localparam int IDX_SUPPLY  = 0;
    localparam int IDX_XRAY    = 1;
    localparam int IDX_STANDBY = 2;
    localparam int IDX_HFLY    = 3;
    localparam int IDX_VFLY    = 4;
    localparam int IDX_VSYNC   = 5;
    localparam int IDX_VRET    = 6;
    localparam int IDX_UNLOCK  = 7;
    localparam int IDX_VFDIS   = 8;
    localparam int NUM_FLAGS   = 9;

endpackage

// File: rtl/defl_sync.sv
module defl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= '0;
            end
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[LAST];

endmodule

// File: rtl/defl_xray_latch.sv
module defl_xray_latch
    import defl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic fault,
    output logic latched
);

    xr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XR_UNPOWERED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XR_UNPOWERED: if (sup_ok) state_d = XR_NORMAL;
            XR_NORMAL:    if (!sup_ok) state_d = XR_UNPOWERED;
                          else if (fault) state_d = XR_TRIPPED;
            XR_TRIPPED:   if (!sup_ok) state_d = XR_UNPOWERED;
            default:      state_d = XR_UNPOWERED;
        endcase
    end

    always_comb begin
        latched = (state_q == XR_TRIPPED);
    end

endmodule

// File: rtl/defl_freq_blank.sv
module defl_freq_blank
    import defl_pkg::*;
#(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic [BLANK_W-1:0] len,
    output logic               active
);

    localparam logic [BLANK_W-1:0] ONE = BLANK_W'(1);

    fb_state_t          state_q, state_d;
    logic [BLANK_W-1:0] cnt_q, cnt_d;
    logic               trig_q;
    logic               trig_edge;

    assign trig_edge = trig & ~trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_IDLE;
            cnt_q   <= '0;
            trig_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            trig_q  <= trig;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FB_IDLE: begin
                if (trig_edge && len != '0) begin
                    state_d = FB_HOLD;
                    cnt_d   = len;
                end
            end
            FB_HOLD: begin
                if (trig_edge && len != '0) begin
                    cnt_d = len;
                end else if (trig_edge || cnt_q <= ONE) begin
                    state_d = FB_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = FB_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        active = (state_q == FB_HOLD);
    end

endmodule

// File: rtl/defl_guard.sv
module defl_guard
    import defl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic               xray_trip,
    input  logic               standby,
    input  logic               hfly,
    input  logic               vfly,
    input  logic               vsync,
    input  logic               vretrace,
    input  logic               unlock,
    input  logic               vfly_dis,
    input  logic [BLANK_W-1:0] blank_len,
    output logic               h_inhibit,
    output logic               v_inhibit,
    output logic               cblank
);

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] syn_flags;

    logic sup_s, xr_s, stby_s, hfly_s, vfly_s, vsync_s, vret_s, unlock_s, vfdis_s;
    logic xr_latched;
    logic fb_active;
    logic vert_blank;

    always_comb begin
        raw_flags              = '0;
        raw_flags[IDX_SUPPLY]  = supply_ok;
        raw_flags[IDX_XRAY]    = xray_trip;
        raw_flags[IDX_STANDBY] = standby;
        raw_flags[IDX_HFLY]    = hfly;
        raw_flags[IDX_VFLY]    = vfly;
        raw_flags[IDX_VSYNC]   = vsync;
        raw_flags[IDX_VRET]    = vretrace;
        raw_flags[IDX_UNLOCK]  = unlock;
        raw_flags[IDX_VFDIS]   = vfly_dis;
    end

    defl_sync #(
        .W      (NUM_FLAGS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_flags),
        .q_sync  (syn_flags)
    );

    assign sup_s    = syn_flags[IDX_SUPPLY];
    assign xr_s     = syn_flags[IDX_XRAY];
    assign stby_s   = syn_flags[IDX_STANDBY];
    assign hfly_s   = syn_flags[IDX_HFLY];
    assign vfly_s   = syn_flags[IDX_VFLY];
    assign vsync_s  = syn_flags[IDX_VSYNC];
    assign vret_s   = syn_flags[IDX_VRET];
    assign unlock_s = syn_flags[IDX_UNLOCK];
    assign vfdis_s  = syn_flags[IDX_VFDIS];

    defl_xray_latch u_xray (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_ok  (sup_s),
        .fault   (xr_s),
        .latched (xr_latched)
    );

    defl_freq_blank #(
        .BLANK_W (BLANK_W)
    ) u_fblank (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (unlock_s),
        .len    (blank_len),
        .active (fb_active)
    );

    always_comb begin
        vert_blank = vfdis_s ? vret_s : vfly_s;
        h_inhibit  = ~sup_s | xr_latched | hfly_s | stby_s;
        v_inhibit  = ~sup_s | stby_s;
        cblank     = ~sup_s | xr_latched | stby_s | hfly_s
                   | vert_blank | vsync_s | fb_active;
    end

endmodule

// File: rtl/defl_guard_chk.sv
module defl_guard_chk #(
    parameter int BLANK_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sup_s,
    input logic               stby_s,
    input logic               unlock_s,
    input logic               xr_latched,
    input logic               fb_active,
    input logic [BLANK_W-1:0] blank_len,
    input logic               h_inhibit,
    input logic               v_inhibit,
    input logic               cblank
);

    assert_xray_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_latched && sup_s) |=> xr_latched);

    assert_xray_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xr_latched |-> (h_inhibit && cblank));

    assert_supply_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> !xr_latched);

    assert_standby_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stby_s |-> (h_inhibit && v_inhibit && cblank));

    assert_vinh_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_s && !stby_s) |-> !v_inhibit);

    assert_window_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(unlock_s) && blank_len != '0) |=> fb_active);

    assert_window_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fb_active |-> cblank);

endmodule

bind defl_guard defl_guard_chk #(.BLANK_W(BLANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_s      (sup_s),
    .stby_s     (stby_s),
    .unlock_s   (unlock_s),
    .xr_latched (xr_latched),
    .fb_active  (fb_active),
    .blank_len  (blank_len),
    .h_inhibit  (h_inhibit),
    .v_inhibit  (v_inhibit),
    .cblank     (cblank)
);

// File: tb/defl_guard_bench.sv
`timescale 1ns/1ps
module defl_guard_bench;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0, xray_trip = 1'b0, standby = 1'b0;
    logic          hfly = 1'b0, vfly = 1'b0, vsync = 1'b0, vretrace = 1'b0;
    logic          unlock = 1'b0, vfly_dis = 1'b0;
    logic [BW-1:0] blank_len = '0;
    logic          h_inhibit, v_inhibit, cblank;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    defl_guard #(.SYNC_STAGES(2), .BLANK_W(BW)) u_defl_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .xray_trip(xray_trip),
        .standby(standby), .hfly(hfly), .vfly(vfly), .vsync(vsync),
        .vretrace(vretrace), .unlock(unlock), .vfly_dis(vfly_dis),
        .blank_len(blank_len), .h_inhibit(h_inhibit), .v_inhibit(v_inhibit),
        .cblank(cblank)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic eh, input logic ev, input logic eb);
        vectors++;
        if (h_inhibit !== eh || v_inhibit !== ev || cblank !== eb) begin
            errors++;
            $display("FAIL %s: h/v/b actual %b%b%b expected %b%b%b",
                     req, h_inhibit, v_inhibit, cblank, eh, ev, eb);
        end
    endtask

    task automatic t_reset_R1;
        tick(1);
        chk("R1", 1, 1, 1);
        rst_n = 1'b1;
        tick(3);
        chk("R1", 1, 1, 1);
        supply_ok = 1'b1;
        tick(1);
        chk("R2", 1, 1, 1);
        tick(1);
        chk("R1", 0, 0, 0);
    endtask

    task automatic t_hflyback_R3;
        hfly = 1'b1;
        tick(1);
        chk("R2", 0, 0, 0);
        tick(1);
        chk("R3", 1, 0, 1);
        hfly = 1'b0;
        tick(2);
        chk("R3", 0, 0, 0);
    endtask

    task automatic t_standby_R7;
        standby = 1'b1;
        tick(2);
        chk("R7", 1, 1, 1);
        standby = 1'b0;
        tick(2);
        chk("R7", 0, 0, 0);
    endtask

    task automatic t_supply_R4;
        supply_ok = 1'b0;
        tick(2);
        chk("R4", 1, 1, 1);
        supply_ok = 1'b1;
        tick(2);
        chk("R4", 0, 0, 0);
    endtask

    task automatic t_blank_terms_R8;
        vsync = 1'b1;
        tick(2);
        chk("R8", 0, 0, 1);
        vsync = 1'b0;
        vfly  = 1'b1;
        tick(2);
        chk("R8", 0, 0, 1);
        vfly     = 1'b0;
        vretrace = 1'b1;
        tick(2);
        chk("R9", 0, 0, 0);
        vretrace = 1'b0;
        tick(2);
    endtask

    task automatic t_vfly_disable_R9;
        vfly_dis = 1'b1;
        vfly     = 1'b1;
        tick(2);
        chk("R9", 0, 0, 0);
        vretrace = 1'b1;
        tick(2);
        chk("R9", 0, 0, 1);
        vfly     = 1'b0;
        vretrace = 1'b0;
        vfly_dis = 1'b0;
        tick(2);
        chk("R9", 0, 0, 0);
    endtask

    task automatic t_xray_R5;
        xray_trip = 1'b1;
        tick(2);
        chk("R5", 0, 0, 0);
        tick(1);
        chk("R5", 1, 0, 1);
        xray_trip = 1'b0;
        tick(5);
        chk("R5", 1, 0, 1);
    endtask

    task automatic t_xray_clear_R6;
        supply_ok = 1'b0;
        tick(4);
        chk("R6", 1, 1, 1);
        supply_ok = 1'b1;
        tick(4);
        chk("R6", 0, 0, 0);
    endtask

    task automatic t_freq_R10;
        blank_len = BW'(10);
        unlock    = 1'b1;
        tick(2);
        chk("R10", 0, 0, 0);
        tick(1);
        chk("R10", 0, 0, 1);
        tick(9);
        chk("R10", 0, 0, 1);
        tick(1);
        chk("R10", 0, 0, 0);
        unlock = 1'b0;
        tick(4);
    endtask

    task automatic t_retrigger_R11;
        blank_len = BW'(10);
        unlock    = 1'b1;
        tick(2);
        unlock = 1'b0;
        tick(2);
        unlock = 1'b1;
        tick(12);
        chk("R11", 0, 0, 1);
        tick(1);
        chk("R11", 0, 0, 0);
        unlock = 1'b0;
        tick(4);
    endtask

    task automatic t_zero_len_R12;
        blank_len = '0;
        unlock    = 1'b1;
        tick(3);
        chk("R12", 0, 0, 0);
        tick(2);
        chk("R12", 0, 0, 0);
        unlock = 1'b0;
        tick(4);
    endtask

    initial begin
        t_reset_R1();
        t_hflyback_R3();
        t_standby_R7();
        t_supply_R4();
        t_blank_terms_R8();
        t_vfly_disable_R9();
        t_xray_R5();
        t_xray_clear_R6();
        t_freq_R10();
        t_retrigger_R11();
        t_zero_len_R12();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule